// File: doc/BRIEF.md
# Watchdog and Reset Controller

This block supervises a small 8-bit controller. It combines three functions. First, it filters the shared, bidirectional reset pin, so that only a sustained high level becomes the chip's internal reset. Second, it runs a watchdog counter that pulls the reset pin high itself when software stops reloading it. Third, it sequences the two low-power states: idle, where only the CPU clock stops, and power-down, where the oscillator stops.

The clock of the block is the oscillator clock, so one clock cycle is one oscillator period. A machine cycle is `OSC_PER_MC` (12) periods. The reset pin is modelled as a sampled input `rst_pin_in` plus a drive enable `rst_pin_oe`; the pad combines the two.

The internal reset is produced only by the pin filter. When the watchdog fires, its pulse returns through the pin and is filtered like any external reset. One path therefore covers both causes of reset.

When the watchdog enable input is high, the watchdog counts and power-down cannot be entered. Software requests a low-power state by writing a control word that holds an idle bit and a power-down bit. It reloads the watchdog by writing a new count.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released: `sys_rst`=0, `rst_pin_oe`=0, `wd_count`=0, `cpu_clk_en`=1, `osc_en`=1, `lp_idle`=0 and `lp_pdown`=0.
- R2: `sys_rst` goes high after `rst_pin_in` has been sampled high on RST_CYC = OSC_PER_MC*RST_MIN_MC (24) consecutive rising edges. It stays high while the pin stays high, and it goes low one edge after the pin is sampled low. A run of 23 high samples never asserts it.
- R3: While `wd_en` is 0, `wd_count` is held at 0 and `wd_load` has no effect.
- R4: While `wd_en` is 1 and the block is neither in reset, driving the pin, nor in power-down, `wd_count` advances by one every `WD_PRESC` cycles. A `wd_load` sets `wd_count` to `wd_load_val` on the next edge and restarts the prescaler.
- R5: When `wd_count` advances from all ones, it wraps to 0 and `rst_pin_oe` is high for exactly RST_CYC cycles, beginning at that edge. `wd_count` does not advance while `rst_pin_oe` is high.
- R6: The watchdog pulse, read back on the pin, raises `sys_rst` for one cycle directly after the pulse ends. `sys_rst` clears the watchdog count and prescaler, and it returns the block to the running state.
- R7: A control write (`ctrl_wr`=1) in the running state with `ctrl_idle`=1, and without a permitted power-down, enters idle: `lp_idle`=1, `cpu_clk_en`=0, `osc_en`=1.
- R8: Idle ends on the edge after `irq_pend` is high, or on `sys_rst`. On exit both mode flags read 0.
- R9: A control write with `ctrl_pdown`=1 while `wd_en`=0 enters power-down: `lp_pdown`=1, `cpu_clk_en`=0, `osc_en`=0. `irq_pend` does not end it; only `sys_rst` does. The watchdog does not advance in power-down.
- R10: While `wd_en`=1, a power-down request is ignored. If `ctrl_idle` is set in the same write, idle is entered instead.
- R11: When `ctrl_idle` and `ctrl_pdown` are both set and `wd_en`=0, power-down wins.
- R12: Control writes made while in idle or power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_in | input | 1 | Sampled level of the reset pin |
| rst_pin_oe | output | 1 | Drives the reset pin high (watchdog pulse) |
| sys_rst | output | 1 | Qualified internal reset |
| wd_en | input | 1 | Watchdog enable; also blocks power-down |
| wd_load | input | 1 | Strobe: reload the watchdog count |
| wd_load_val | input | WD_W | Value for the reload |
| wd_count | output | WD_W | Current watchdog count |
| ctrl_wr | input | 1 | Strobe: control word write |
| ctrl_idle | input | 1 | Idle request bit of the control word |
| ctrl_pdown | input | 1 | Power-down request bit of the control word |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator and peripheral clock enable |
| lp_idle | output | 1 | Idle flag |
| lp_pdown | output | 1 | Power-down flag |

## Verification
The bench builds the block with `WD_PRESC` = 4 and keeps the default 8-bit counter and the 12×2 reset window. A full watchdog period is then about a thousand cycles, so random runs reach several overflows, pulses and the self-reset that follows. The reset window is unchanged, so the 23 and 24 cycle boundaries are checked at their real lengths. A cycle-level reference model in the bench is compared with every output on every cycle, alongside directed cases for each mode-priority corner.

// File: rtl/wdt_rc_pkg.sv
package wdt_rc_pkg;
  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_IDLE = 2'd1,
    LP_DOWN = 2'd2
  } lp_state_t;
endpackage

// File: rtl/wdt_rst_qual.sv
// Reset pin filter: counts consecutive high samples, saturating at the window.
module wdt_rst_qual #(
  parameter int RST_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic sys_rst
);
  localparam int QW = $clog2(RST_CYC + 1);
  localparam logic [QW-1:0] FULL = QW'(RST_CYC);

  logic [QW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_cnt <= '0;
    else if (!pin_in)       hi_cnt <= '0;
    else if (hi_cnt != FULL) hi_cnt <= hi_cnt + 1'b1;
  end

  assign sys_rst = (hi_cnt == FULL);

  p_rst_needs_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past(pin_in));
  p_rst_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_in |=> !sys_rst);
endmodule

// File: rtl/wdt_core.sv
// Watchdog prescaler and counter.
module wdt_core #(
  parameter int WD_W     = 8,
  parameter int WD_PRESC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [WD_W-1:0] load_val,
  input  logic            run,
  output logic [WD_W-1:0] count,
  output logic            ovf
);
  logic tick;

  generate
    if (WD_PRESC == 1) begin : g_no_presc
      assign tick = run;
    end else begin : g_presc
      localparam int PW = $clog2(WD_PRESC);
      localparam logic [PW-1:0] LAST = PW'(WD_PRESC - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre <= '0;
        else if (clr || load) pre <= '0;
        else if (run)         pre <= (pre == LAST) ? '0 : pre + 1'b1;
      end
      assign tick = run && (pre == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (load)  count <= load_val;
    else if (tick)  count <= count + 1'b1;
  end

  assign ovf = tick && !load && !clr && (&count);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val)));
  p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !load) |=> $stable(count));
endmodule

// File: rtl/wdt_pulse.sv
// Fixed-length drive pulse for the reset pin.
module wdt_pulse #(
  parameter int PULSE_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic drive
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_CYC);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (fire)       left <= LEN;
    else if (left != '0) left <= left - 1'b1;
  end

  assign drive = (left != '0);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> drive);
  p_no_refire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !fire);
endmodule

// File: rtl/wdt_lp_ctrl.sv
// Idle / power-down sequencing.
module wdt_lp_ctrl
  import wdt_rc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sys_rst,
  input  logic      ctrl_wr,
  input  logic      req_idle,
  input  logic      req_pdown,
  input  logic      wd_en,
  input  logic      irq_pend,
  output lp_state_t state
);
  lp_state_t nxt;

  always_comb begin
    nxt = state;
    if (sys_rst) begin
      nxt = LP_RUN;
    end else begin
      unique case (state)
        LP_RUN: begin
          if (ctrl_wr) begin
            if (req_pdown && !wd_en) nxt = LP_DOWN;
            else if (req_idle)       nxt = LP_IDLE;
          end
        end
        LP_IDLE: if (irq_pend) nxt = LP_RUN;
        LP_DOWN: nxt = LP_DOWN;
        default: nxt = LP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LP_RUN;
    else        state <= nxt;
  end

  p_pd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_DOWN && !sys_rst) |=> (state == LP_DOWN));
  p_pd_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_DOWN && wd_en) |=> (state != LP_DOWN));
  p_exit_on_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (state == LP_RUN));
  p_no_write_in_lp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_IDLE && !irq_pend && !sys_rst) |=> (state == LP_IDLE));
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
  import wdt_rc_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int RST_MIN_MC = 2,
  parameter int WD_W       = 8,
  parameter int WD_PRESC   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin_in,
  output logic            rst_pin_oe,
  output logic            sys_rst,
  input  logic            wd_en,
  input  logic            wd_load,
  input  logic [WD_W-1:0] wd_load_val,
  output logic [WD_W-1:0] wd_count,
  input  logic            ctrl_wr,
  input  logic            ctrl_idle,
  input  logic            ctrl_pdown,
  input  logic            irq_pend,
  output logic            cpu_clk_en,
  output logic            osc_en,
  output logic            lp_idle,
  output logic            lp_pdown
);
  localparam int RST_CYC = OSC_PER_MC * RST_MIN_MC;

  lp_state_t lp_st;
  logic      wd_clr, wd_run, wd_ovf;

  wdt_rst_qual #(.RST_CYC(RST_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_in(rst_pin_in), .sys_rst(sys_rst)
  );

  assign wd_clr = sys_rst || !wd_en;
  assign wd_run = !rst_pin_oe && (lp_st != LP_DOWN);

  wdt_core #(.WD_W(WD_W), .WD_PRESC(WD_PRESC)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .load(wd_load),
    .load_val(wd_load_val), .run(wd_run), .count(wd_count), .ovf(wd_ovf)
  );

  wdt_pulse #(.PULSE_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(wd_ovf), .drive(rst_pin_oe)
  );

  wdt_lp_ctrl u_lp (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .ctrl_wr(ctrl_wr),
    .req_idle(ctrl_idle), .req_pdown(ctrl_pdown), .wd_en(wd_en),
    .irq_pend(irq_pend), .state(lp_st)
  );

  assign lp_idle    = (lp_st == LP_IDLE);
  assign lp_pdown   = (lp_st == LP_DOWN);
  assign cpu_clk_en = (lp_st == LP_RUN);
  assign osc_en     = (lp_st != LP_DOWN);

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_idle, lp_pdown}));
  p_frozen_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin_oe && !sys_rst && wd_en && !wd_load) |=> $stable(wd_count));
endmodule

// File: tb/wdt_rst_ctrl_bench.sv
`timescale 1ns/1ps
module wdt_rst_ctrl_bench;
  localparam int PR  = 4;
  localparam int RC  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b0;
  logic rst_pin_in, rst_pin_oe, sys_rst;
  logic wd_en = 1'b0, wd_load = 1'b0;
  logic [7:0] wd_load_val = 8'h00;
  logic [7:0] wd_count;
  logic ctrl_wr = 1'b0, ctrl_idle = 1'b0, ctrl_pdown = 1'b0, irq_pend = 1'b0;
  logic cpu_clk_en, osc_en, lp_idle, lp_pdown;

  int checks = 0;
  int errors = 0;

  // reference model state
  int mq = 0, mc = 0, mp = 0, mpls = 0, mst = 0;

  always #4 clk = ~clk;
  assign rst_pin_in = ext_rst | rst_pin_oe;

  wdt_rst_ctrl #(.WD_PRESC(PR)) u_wdt_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_pin_in(rst_pin_in), .rst_pin_oe(rst_pin_oe),
    .sys_rst(sys_rst), .wd_en(wd_en), .wd_load(wd_load), .wd_load_val(wd_load_val),
    .wd_count(wd_count), .ctrl_wr(ctrl_wr), .ctrl_idle(ctrl_idle),
    .ctrl_pdown(ctrl_pdown), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .lp_idle(lp_idle), .lp_pdown(lp_pdown)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nq(input int q, input bit pin);
    if (!pin) return 0;
    return (q == RC) ? RC : q + 1;
  endfunction

  task automatic model_step();
    bit pin, sr, ovf, tick;
    if (!rst_n) begin
      mq = 0; mc = 0; mp = 0; mpls = 0; mst = 0;
      return;
    end
    pin = ext_rst | (mpls != 0);
    sr  = (mq == RC);
    ovf = 1'b0;
    if (sr || !wd_en) begin
      mc = 0; mp = 0;
    end else if (wd_load) begin
      mc = int'(wd_load_val); mp = 0;
    end else if (mpls == 0 && mst != 2) begin
      tick = (mp == PR - 1);
      mp = tick ? 0 : mp + 1;
      if (tick) begin
        ovf = (mc == 255);
        mc = (mc + 1) % 256;
      end
    end
    if (ovf) mpls = RC;
    else if (mpls != 0) mpls = mpls - 1;
    if (sr) mst = 0;
    else if (mst == 0 && ctrl_wr) begin
      if (ctrl_pdown && !wd_en) mst = 2;
      else if (ctrl_idle) mst = 1;
    end else if (mst == 1 && irq_pend) mst = 0;
    mq = nq(mq, pin);
  endtask

  task automatic compare();
    check("R2 sys_rst", int'(sys_rst), int'(mq == RC));
    check("R5 rst_pin_oe", int'(rst_pin_oe), int'(mpls != 0));
    check("R4 wd_count", int'(wd_count), mc);
    check("R7 lp_idle", int'(lp_idle), int'(mst == 1));
    check("R9 lp_pdown", int'(lp_pdown), int'(mst == 2));
    check("R9 osc_en", int'(osc_en), int'(mst != 2));
    check("R7 cpu_clk_en", int'(cpu_clk_en), int'(mst == 0));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ctrl(input bit idl, input bit pd);
    ctrl_wr = 1'b1; ctrl_idle = idl; ctrl_pdown = pd;
    cyc();
    ctrl_wr = 1'b0; ctrl_idle = 1'b0; ctrl_pdown = 1'b0;
  endtask

  task automatic ext_reset(input int n);
    ext_rst = 1'b1;
    cycles(n);
    ext_rst = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seen;
    int burst;
    void'($urandom(32'd20240611));
    // R1: reset state
    @(negedge clk);
    check("R1 sys_rst in reset", int'(sys_rst), 0);
    check("R1 oe in reset", int'(rst_pin_oe), 0);
    check("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
    cycles(2);
    rst_n = 1'b1;
    cyc();
    check("R1 count after reset", int'(wd_count), 0);
    check("R1 osc_en after reset", int'(osc_en), 1);
    check("R1 flags after reset", int'({lp_idle, lp_pdown}), 0);

    // R3: disabled watchdog ignores loads
    wd_load = 1'b1; wd_load_val = 8'h50; cyc(); wd_load = 1'b0;
    cycles(20);
    check("R3 count held while disabled", int'(wd_count), 0);

    // R2: 23 cycles short, 24 accepted
    seen = 0;
    ext_rst = 1'b1;
    for (int i = 0; i < 23; i++) begin cyc(); if (sys_rst) seen = 1; end
    ext_rst = 1'b0;
    cyc(); if (sys_rst) seen = 1;
    check("R2 23 cycle pulse rejected", seen, 0);
    ext_rst = 1'b1;
    cycles(24);
    check("R2 24 cycle pulse accepted", int'(sys_rst), 1);
    cycles(5);
    check("R2 held while pin high", int'(sys_rst), 1);
    ext_rst = 1'b0;
    cyc();
    check("R2 release after pin low", int'(sys_rst), 0);

    // R4: counting and load
    wd_en = 1'b1;
    wd_load = 1'b1; wd_load_val = 8'hF0; cyc(); wd_load = 1'b0;
    check("R4 load value", int'(wd_count), 8'hF0);
    cycles(PR);
    check("R4 one step per prescale period", int'(wd_count), 8'hF1);

    // R5/R6: overflow pulse and self reset, from idle
    ctrl(1'b1, 1'b0);
    check("R7 idle entered", int'(lp_idle), 1);
    seen = 0;
    for (int i = 0; i < 200 && !rst_pin_oe; i++) cyc();
    check("R5 pulse started", int'(rst_pin_oe), 1);
    check("R5 count wrapped", int'(wd_count), 0);
    while (rst_pin_oe && seen < 100) begin seen++; cyc(); end
    check("R5 pulse length", seen, RC);
    check("R6 self reset after pulse", int'(sys_rst), 1);
    cyc();
    check("R6 one cycle reset", int'(sys_rst), 0);
    check("R6 reset leaves idle", int'(lp_idle), 0);
    check("R6 reset clears count", int'(wd_count), 0);

    // R8: idle ended by interrupt
    wd_en = 1'b0;
    ctrl(1'b1, 1'b0);
    cycles(3);
    check("R8 idle held", int'(lp_idle), 1);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    check("R8 idle exit on interrupt", int'({lp_idle, lp_pdown}), 0);

    // R9: power-down with watchdog off
    ctrl(1'b0, 1'b1);
    check("R9 power-down entered", int'(lp_pdown), 1);
    check("R9 oscillator stopped", int'(osc_en), 0);
    irq_pend = 1'b1; cycles(3); irq_pend = 1'b0;
    check("R9 interrupt ignored", int'(lp_pdown), 1);
    ext_reset(RC);
    check("R9 reset exits power-down", int'(lp_pdown), 0);

    // R10: blocked by watchdog enable
    wd_en = 1'b1;
    ctrl(1'b0, 1'b1);
    check("R10 power-down ignored", int'({lp_idle, lp_pdown}), 0);
    ctrl(1'b1, 1'b1);
    check("R10 idle taken instead", int'(lp_idle), 1);
    // R12: writes ignored in idle
    ctrl(1'b0, 1'b1);
    check("R12 write in idle ignored", int'({lp_idle, lp_pdown}), 2);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;

    // R11: both bits, watchdog off
    wd_en = 1'b0;
    ctrl(1'b1, 1'b1);
    check("R11 power-down wins", int'({lp_idle, lp_pdown}), 1);
    ext_reset(RC + 2);

    // random phase
    burst = 0;
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(59) == 0) wd_en = ~wd_en;
      wd_load = ($urandom_range(299) == 0);
      wd_load_val = 8'($urandom());
      ctrl_wr = ($urandom_range(29) == 0);
      ctrl_idle = $urandom_range(1) == 1;
      ctrl_pdown = $urandom_range(1) == 1;
      irq_pend = ($urandom_range(24) == 0);
      if (burst == 0 && $urandom_range(399) == 0) burst = 10 + $urandom_range(30);
      ext_rst = (burst != 0);
      if (burst != 0) burst--;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule